// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block paces a sampling converter through its two alternating phases: a fixed-length acquisition window, during which the input is tracked, and a fixed-length conversion window, during which the sampled value is held and resolved. Both lengths are parameters counted in clock cycles. The converted value is not produced here. It is taken from a test input port at the end of conversion and captured into an output result register.

The level of the start input at the end of acquisition decides how the next conversion is triggered. A low level begins conversion on the very next cycle. A high level parks the sequencer until that input falls, which lets a system place the sampling instant precisely. `busy_o` and `hold_o` mark the conversion window. A one-cycle strobe, coincident with the falling edge of busy, tells the output port that fresh data is ready.

A synchronous abort input cancels a conversion in progress and restarts acquisition. A power-down input lets a running conversion finish and latch its result, then blocks further conversions until it is released.

Top module: `conv_seq`

## Requirements
- R1: While `rst_n` is low and afterwards until the first conversion, `busy_o`, `hold_o` and `latch_o` are low and `result_o` is zero; with the start input held high the block never leaves that idle condition on its own.
- R2: Acquisition lasts exactly ACQ_CYCLES clock cycles; if `cnv_start_i` is low in its last cycle, `busy_o` and `hold_o` are high in the following cycle.
- R3: If `cnv_start_i` is high in the last acquisition cycle, `busy_o` stays low for as long as the input stays high, and goes high in the cycle after the first cycle in which the input is sampled low.
- R4: Once raised, `busy_o` stays high for exactly CONV_CYCLES cycles unless aborted.
- R5: `latch_o` is high for exactly one cycle, the first cycle in which `busy_o` is low again. In that cycle `result_o` equals `test_value_i` as sampled in the last conversion cycle, and `result_o` changes at no other time.
- R6: Changes of `cnv_start_i`, including falling edges, that occur during acquisition or conversion have no effect on when conversion begins or how long it lasts.
- R7: A cycle with `abort_i` high forces `busy_o` low in the next cycle with no `latch_o` pulse and no change of `result_o`, and a full ACQ_CYCLES acquisition starts again.
- R8: Raising `pwrdn_i` during conversion lets it run to completion and latch its result; while `pwrdn_i` stays high no new conversion starts, whatever the level of `cnv_start_i`.
- R9: After `pwrdn_i` returns low, a full acquisition restarts, so with the start input low `busy_o` rises ACQ_CYCLES+1 cycles after the release is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnv_start_i | input | 1 | Conversion start level and trigger |
| abort_i | input | 1 | Synchronous abort of the current cycle, restarts acquisition |
| pwrdn_i | input | 1 | Power-down request, deferred until a conversion ends |
| test_value_i | input | DATA_W | Value standing in for the converter output |
| busy_o | output | 1 | High during conversion |
| hold_o | output | 1 | Sample-and-hold in hold state |
| latch_o | output | 1 | One-cycle strobe when the result is captured |
| result_o | output | DATA_W | Latched conversion result |

## Verification
The hardest state to reach is the deferred power-down. The request has to arrive partway through a conversion, and afterwards two things must be shown together: that the conversion still completes, and that a low start level, which would normally trigger an immediate conversion, is refused. The stimulus starts an immediate-mode conversion, raises `pwrdn_i` a few cycles into it, and holds the start input low through a long quiet stretch before releasing. Ignored start edges are reached by pulsing the start input against its intended level in the middle of acquisition and again in the middle of conversion.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    ST_ACQ  = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2,
    ST_PD   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             at_limit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == limit);
endmodule

// File: rtl/start_edge.sv
module start_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= start_i;
  end

  assign fall = prev_q & ~start_i;
endmodule

// File: rtl/result_hold.sv
module result_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic              strobe
);
  logic [DATA_W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      strobe <= 1'b0;
    end else begin
      q      <= q_d;
      strobe <= load;
    end
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ACQ_CYCLES  = 8,
  parameter int CONV_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_start_i,
  input  logic              abort_i,
  input  logic              pwrdn_i,
  input  logic [DATA_W-1:0] test_value_i,
  output logic              busy_o,
  output logic              hold_o,
  output logic              latch_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int MAX_CYC = (ACQ_CYCLES > CONV_CYCLES) ? ACQ_CYCLES : CONV_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACQ_LIM  = CNT_W'(ACQ_CYCLES - 1);
  localparam logic [CNT_W-1:0] CONV_LIM = CNT_W'(CONV_CYCLES - 1);

  logic       rst_n_int;
  seq_state_t state_q, state_d;
  logic       at_limit, start_fall, tmr_clr, tmr_en, load;
  logic [CNT_W-1:0] limit;

  seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  start_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (cnv_start_i),
    .fall    (start_fall)
  );

  assign limit   = (state_q == ST_CONV) ? CONV_LIM : ACQ_LIM;
  assign tmr_en  = (state_q == ST_ACQ) || (state_q == ST_CONV);
  assign tmr_clr = abort_i || (state_d != state_q);

  phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr      (tmr_clr),
    .en       (tmr_en),
    .limit    (limit),
    .at_limit (at_limit)
  );

  always_comb begin
    state_d = state_q;
    if (abort_i) begin
      state_d = ST_ACQ;
    end else begin
      unique case (state_q)
        ST_ACQ: begin
          if (pwrdn_i)       state_d = ST_PD;
          else if (at_limit) state_d = cnv_start_i ? ST_WAIT : ST_CONV;
        end
        ST_WAIT: begin
          if (pwrdn_i)         state_d = ST_PD;
          else if (start_fall) state_d = ST_CONV;
        end
        ST_CONV: begin
          if (at_limit) state_d = pwrdn_i ? ST_PD : ST_ACQ;
        end
        ST_PD: begin
          if (!pwrdn_i) state_d = ST_ACQ;
        end
        default: state_d = ST_ACQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) state_q <= ST_ACQ;
    else            state_q <= state_d;
  end

  assign load = (state_q == ST_CONV) && at_limit && !abort_i;

  result_hold #(.DATA_W(DATA_W)) u_res (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load   (load),
    .d      (test_value_i),
    .q      (result_o),
    .strobe (latch_o)
  );

  assign busy_o = (state_q == ST_CONV);
  assign hold_o = (state_q == ST_CONV);
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort_i,
  input logic              pwrdn_i,
  input logic              busy_o,
  input logic              latch_o,
  input logic [DATA_W-1:0] result_o
);
  localparam int RUN_W = $clog2(CONV_CYCLES + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_q < RUN_W'(CONV_CYCLES)));

  assert_latch_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !$past(abort_i)) |-> latch_o);

  assert_latch_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |=> !latch_o);

  assert_result_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_o |-> $stable(result_o));

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !latch_o));

  assert_pd_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_i && !busy_o) |=> !busy_o);
endmodule

bind conv_seq conv_seq_chk #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .abort_i  (abort_i),
  .pwrdn_i  (pwrdn_i),
  .busy_o   (busy_o),
  .latch_o  (latch_o),
  .result_o (result_o)
);

// File: tb/conv_seq_tb_top.sv
module conv_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int ACQ  = 8;
  localparam int CONV = 12;
  localparam int NVEC = 6;
  // vector fields: {start_high, wait_cycles[7:0], glitch, value[15:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 8'd0,  1'b0, 16'h1234},
    {1'b1, 8'd0,  1'b0, 16'hFFFF},
    {1'b1, 8'd5,  1'b0, 16'h0000},
    {1'b0, 8'd0,  1'b1, 16'hA5A5},
    {1'b1, 8'd17, 1'b1, 16'h8001},
    {1'b0, 8'd0,  1'b0, 16'h7FFE}
  };

  logic          clk = 1'b0;
  logic          rst_n, cnv_start_i, abort_i, pwrdn_i;
  logic [DW-1:0] test_value_i;
  logic          busy_o, hold_o, latch_o;
  logic [DW-1:0] result_o;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_seq #(.DATA_W(DW), .ACQ_CYCLES(ACQ), .CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnv_start_i(cnv_start_i), .abort_i(abort_i),
    .pwrdn_i(pwrdn_i), .test_value_i(test_value_i), .busy_o(busy_o),
    .hold_o(hold_o), .latch_o(latch_o), .result_o(result_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run_vec(input bit st_hi, input int wait_n, input bit glitch, input logic [DW-1:0] val);
    @(negedge clk); cnv_start_i = st_hi; test_value_i = val; abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    for (int i = 0; i < ACQ-1; i++) begin
      if (glitch && i == 1) cnv_start_i = !st_hi;   // R6 pulse during acquisition
      if (glitch && i == 2) cnv_start_i = st_hi;
      @(negedge clk);
    end
    chk(busy_o == 1'b0, "R2 busy low through acquisition", busy_o, 0);
    if (st_hi) begin
      for (int i = 0; i < wait_n; i++) @(negedge clk);
      chk(busy_o == 1'b0, "R3 waits while start high", busy_o, 0);
      cnv_start_i = 1'b0;
      @(negedge clk);
      chk(busy_o == 1'b1, "R3 conversion after fall", busy_o, 1);
    end else begin
      @(negedge clk);
      chk(busy_o && hold_o, "R2 immediate start", {busy_o, hold_o}, 3);
    end
    for (int i = 0; i < CONV-1; i++) begin
      if (glitch && i == 2) cnv_start_i = 1'b1;     // R6 pulse during conversion
      if (glitch && i == 4) cnv_start_i = 1'b0;
      @(negedge clk);
    end
    chk(busy_o == 1'b1 && latch_o == 1'b0, "R4 R6 busy through conversion", {busy_o, latch_o}, 2);
    @(negedge clk);
    chk(busy_o == 1'b0 && latch_o == 1'b1, "R4 R5 end of busy with strobe", {busy_o, latch_o}, 1);
    chk(result_o == val, "R5 result captured", result_o, val);
    @(negedge clk);
    chk(latch_o == 1'b0, "R5 single strobe", latch_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit quiet;
    logic [DW-1:0] prev;
    rst_n = 1'b0; cnv_start_i = 1'b1; abort_i = 1'b0; pwrdn_i = 1'b0; test_value_i = 16'h5555;
    repeat (3) @(negedge clk);
    chk(!busy_o && !hold_o && !latch_o && result_o == 0, "R1 reset state",
        {busy_o, hold_o, latch_o, result_o}, 0);
    rst_n = 1'b1;
    quiet = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (busy_o || latch_o || result_o != 0) quiet = 1'b0;
    end
    chk(quiet, "R1 idle with start high", quiet, 1);

    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][25], int'(VEC[v][24:17]), VEC[v][16], VEC[v][15:0]);

    // R7: abort in the middle of a conversion
    prev = result_o;
    @(negedge clk); cnv_start_i = 1'b0; test_value_i = 16'h3C3C; abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    repeat (ACQ) @(negedge clk);
    chk(busy_o == 1'b1, "R7 setup conversion", busy_o, 1);
    repeat (5) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    chk(!busy_o && !latch_o, "R7 abort drops busy", {busy_o, latch_o}, 0);
    chk(result_o == prev, "R7 result kept", result_o, prev);
    repeat (ACQ-1) @(negedge clk);
    chk(busy_o == 1'b0, "R7 full acquisition restart", busy_o, 0);
    @(negedge clk);
    chk(busy_o == 1'b1, "R7 conversion after restart", busy_o, 1);
    repeat (CONV-1) @(negedge clk);
    @(negedge clk);
    chk(latch_o && result_o == 16'h3C3C, "R7 later result", result_o, 16'h3C3C);

    // R8/R9: power-down requested mid-conversion
    @(negedge clk); test_value_i = 16'h0F0F; abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    repeat (ACQ) @(negedge clk);
    chk(busy_o == 1'b1, "R8 setup conversion", busy_o, 1);
    repeat (3) @(negedge clk);
    pwrdn_i = 1'b1;
    repeat (CONV-4) @(negedge clk);
    chk(busy_o == 1'b1, "R8 conversion continues", busy_o, 1);
    @(negedge clk);
    chk(!busy_o && latch_o && result_o == 16'h0F0F, "R8 finishes and latches",
        {busy_o, latch_o, result_o}, {2'b01, 16'h0F0F});
    quiet = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy_o) quiet = 1'b0;
    end
    chk(quiet, "R8 no conversion while powered down", quiet, 1);
    pwrdn_i = 1'b0;
    repeat (ACQ) @(negedge clk);
    chk(busy_o == 1'b0, "R9 acquisition after release", busy_o, 0);
    @(negedge clk);
    chk(busy_o == 1'b1, "R9 conversion after release", busy_o, 1);
    repeat (CONV) @(negedge clk);
    chk(latch_o == 1'b1, "R9 result after release", latch_o, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule